// File: doc/BRIEF.md
# Progressive Line Generator with Weave and Interpolate Rules

This block turns one interlaced picture, held as an even field and an odd field in an internal two-field line store, into a progressive frame. It streams that frame as 24-bit RGB pixels. Each output frame has twice as many lines as a field. A frame-level mode decides how the lines are formed. The weave rule takes output lines alternately from the even and the odd field. The interpolate rule keeps only the even field and builds every other line as a vertical average of its neighbours.

The store is loaded through a plain write port: field, line, pixel, data. The geometry (pixels per line, lines per field) and the mode are plain control inputs. The output is a valid/ready stream. A pixel moves on a rising edge where both valid and ready are high. When ready is low the presented pixel and its sync flags are held, and scanning pauses. The stream runs without gaps and repeats the frame for as long as ready allows. Valid never drops once it has risen.

Top module: `plg_line_gen`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, `pix_valid` is low. After release, valid rises on the first clock and then stays high.
- R2: With mode 0 (weave), output line 2k carries pixels of even-field line k and output line 2k+1 carries odd-field line k. Even field is `wr_field`=0, odd is 1.
- R3: With mode 1 (interpolate), output line 2k carries even-field line k. Output line 2k+1 carries, per 8-bit channel (R in bits 23:16, G 15:8, B 7:0), the floor of the mean of even-field lines k and k+1.
- R4: With mode 1, the last output line (2·lines_per_field−1) repeats even-field line lines_per_field−1.
- R5: `pix_hsync` is high exactly on the first pixel (pixel 0) of every output line.
- R6: `pix_vsync` is high exactly on the first pixel of line 0 of every output frame.
- R7: While `pix_valid` is high and `pix_ready` is low, data, hsync, vsync and valid keep their values on the next cycle, and the scan position does not advance.
- R8: A change on `mode` is taken up only by the first pixel of the next frame. The frame in progress keeps the rule it started with.
- R9: Each frame has exactly pixels_per_line × 2·lines_per_field transferred pixels. The scan runs line by line, pixel 0 first, and wraps to line 0 after the last line.
- R10: Any mode value other than 1, including the reserved value 2, follows the weave rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Line rule: 1 interpolate, others weave |
| pixels_per_line | input | 16 | Pixels per line, 1..LINE_W |
| lines_per_field | input | 16 | Lines per field, 1..MAX_LINES |
| wr_en | input | 1 | Store write strobe |
| wr_field | input | 1 | Field written: 0 even, 1 odd |
| wr_line | input | LOG2_LINES | Field line written |
| wr_pix | input | LOG2_LINE_W | Pixel index written |
| wr_data | input | 24 | RGB pixel written |
| pix_data | output | 24 | Output RGB pixel |
| pix_vsync | output | 1 | First pixel of frame |
| pix_hsync | output | 1 | First pixel of line |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Downstream ready |

## Verification
A scan counter that is off by even one step appears at the ports as a wrong pixel value and a misplaced hsync or vsync. This shows up on the very next transfer and persists for the rest of the frame. A wrong field or line select, or a bad averaging carry, shows up on the first pixel of the affected line. A frame-mode latch that updates mid-frame corrupts the next odd line, within one line time. A stall that leaks an advance is visible on the cycle after ready returns. The reference model compares every cycle, so each of these faults is reported where it first appears.

// File: rtl/plg_pkg.sv
package plg_pkg;
  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  localparam logic [1:0] MODE_INTERP = 2'd1;

  function automatic logic [7:0] chan_mean(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[8:1];
  endfunction

  function automatic rgb_t rgb_mean(input rgb_t a, input rgb_t b);
    rgb_t o;
    o.r = chan_mean(a.r, b.r);
    o.g = chan_mean(a.g, b.g);
    o.b = chan_mean(a.b, b.b);
    return o;
  endfunction
endpackage

// File: rtl/plg_field_store.sv
module plg_field_store #(
  parameter int LOG2_LINE_W = 4,
  parameter int LOG2_LINES  = 3
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic                   wr_field,
  input  logic [LOG2_LINES-1:0]  wr_line,
  input  logic [LOG2_LINE_W-1:0] wr_pix,
  input  logic [23:0]            wr_data,
  input  logic                   rd_a_field,
  input  logic [LOG2_LINES-1:0]  rd_a_line,
  input  logic [LOG2_LINES-1:0]  rd_b_line,
  input  logic [LOG2_LINE_W-1:0] rd_pix,
  output logic [23:0]            rd_a_data,
  output logic [23:0]            rd_b_data
);
  localparam int AW    = 1 + LOG2_LINES + LOG2_LINE_W;
  localparam int DEPTH = 1 << AW;

  logic [23:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_field, wr_line, wr_pix}] <= wr_data;
  end

  // port A serves either field, port B only the kept (even) field
  assign rd_a_data = mem[{rd_a_field, rd_a_line, rd_pix}];
  assign rd_b_data = mem[{1'b0, rd_b_line, rd_pix}];
endmodule

// File: rtl/plg_scan_ctr.sv
module plg_scan_ctr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  input  logic [15:0] ppl,
  input  logic [15:0] lpf,
  output logic [15:0] pix,
  output logic [16:0] line,
  output logic        sof,
  output logic        sol
);
  logic [16:0] frame_lines;
  logic        last_pix, last_line;

  assign frame_lines = {lpf, 1'b0};
  assign last_pix    = pix >= (ppl - 16'd1);
  assign last_line   = line >= (frame_lines - 17'd1);
  assign sol         = (pix == 16'd0);
  assign sof         = sol && (line == 17'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix  <= '0;
      line <= '0;
    end else if (adv) begin
      if (last_pix) begin
        pix  <= '0;
        line <= last_line ? 17'd0 : line + 17'd1;
      end else begin
        pix <= pix + 16'd1;
      end
    end
  end

  assert_pix_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ppl != 16'd0) |-> (pix < ppl));
  assert_line_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lpf != 16'd0) |-> (line < frame_lines));
  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(pix) && $stable(line)));
endmodule

// File: rtl/plg_line_gen.sv
module plg_line_gen
  import plg_pkg::*;
#(
  parameter int LINE_W      = 16,
  parameter int LOG2_LINE_W = 4,
  parameter int MAX_LINES   = 8,
  parameter int LOG2_LINES  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             mode,
  input  logic [15:0]            pixels_per_line,
  input  logic [15:0]            lines_per_field,
  input  logic                   wr_en,
  input  logic                   wr_field,
  input  logic [LOG2_LINES-1:0]  wr_line,
  input  logic [LOG2_LINE_W-1:0] wr_pix,
  input  logic [23:0]            wr_data,
  output logic [23:0]            pix_data,
  output logic                   pix_vsync,
  output logic                   pix_hsync,
  output logic                   pix_valid,
  input  logic                   pix_ready
);
  logic        load, sof, sol, interp, has_below;
  logic [15:0] pix;
  logic [16:0] line;
  logic [15:0] k_full;
  logic [1:0]  frame_mode, eff_mode;
  logic [LOG2_LINES-1:0] a_line, b_line;
  rgb_t        a_data, b_data, sel;

  assign load     = !pix_valid || pix_ready;
  assign eff_mode = sof ? mode : frame_mode;
  assign interp   = (eff_mode == MODE_INTERP);
  assign k_full   = line[16:1];
  assign a_line   = k_full[LOG2_LINES-1:0];
  assign b_line   = a_line + 1'b1;
  assign has_below = ({1'b0, k_full} + 17'd1) < {1'b0, lines_per_field};

  plg_scan_ctr u_scan (
    .clk(clk), .rst_n(rst_n), .adv(load),
    .ppl(pixels_per_line), .lpf(lines_per_field),
    .pix(pix), .line(line), .sof(sof), .sol(sol)
  );

  plg_field_store #(.LOG2_LINE_W(LOG2_LINE_W), .LOG2_LINES(LOG2_LINES)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_field(wr_field), .wr_line(wr_line),
    .wr_pix(wr_pix), .wr_data(wr_data),
    .rd_a_field(interp ? 1'b0 : line[0]),
    .rd_a_line(a_line), .rd_b_line(b_line),
    .rd_pix(pix[LOG2_LINE_W-1:0]),
    .rd_a_data(a_data), .rd_b_data(b_data)
  );

  always_comb begin
    if (interp && line[0] && has_below) sel = rgb_mean(a_data, b_data);
    else                                sel = a_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid  <= 1'b0;
      pix_data   <= '0;
      pix_vsync  <= 1'b0;
      pix_hsync  <= 1'b0;
      frame_mode <= '0;
    end else if (load) begin
      pix_valid <= 1'b1;
      pix_data  <= sel;
      pix_vsync <= sof;
      pix_hsync <= sol;
      if (sof) frame_mode <= mode;
    end
  end

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data) &&
                                   $stable(pix_vsync) && $stable(pix_hsync)));
  assert_valid_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> pix_valid);
  assert_vsync_on_line_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vsync |-> pix_hsync);
  assert_mode_frame_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && sof) |=> $stable(frame_mode));
endmodule

// File: tb/plg_line_gen_tb.sv
module plg_line_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_W = 16, LOG2_LINE_W = 4, MAX_LINES = 8, LOG2_LINES = 3;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic [15:0] ppl = 5, lpf = 4;
  logic wr_en = 0, wr_field = 0;
  logic [LOG2_LINES-1:0] wr_line = 0;
  logic [LOG2_LINE_W-1:0] wr_pix = 0;
  logic [23:0] wr_data = 0;
  logic [23:0] pix_data;
  logic pix_vsync, pix_hsync, pix_valid;
  logic pix_ready = 0;

  int vectors = 0, errors = 0;
  int has = 0, rp = 0, rl = 0, rmode = 0, prev_stall = 0;
  int xfer_cnt = 0, seen_frame = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  plg_line_gen #(.LINE_W(LINE_W), .LOG2_LINE_W(LOG2_LINE_W),
                 .MAX_LINES(MAX_LINES), .LOG2_LINES(LOG2_LINES)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .pixels_per_line(ppl), .lines_per_field(lpf),
    .wr_en(wr_en), .wr_field(wr_field), .wr_line(wr_line),
    .wr_pix(wr_pix), .wr_data(wr_data),
    .pix_data(pix_data), .pix_vsync(pix_vsync), .pix_hsync(pix_hsync),
    .pix_valid(pix_valid), .pix_ready(pix_ready)
  );

  function automatic logic [23:0] pv(int f, int l, int p);
    int r, g, b;
    r = (f*131 + l*53 + p*29 + 7) & 255;
    g = (f*17 + l*89 + p*41 + 200) & 255;
    b = (l*l*13 + p*p*7 + f*3 + 1) & 255;
    return {r[7:0], g[7:0], b[7:0]};
  endfunction

  function automatic logic [23:0] expect_px(int md, int l, int p, int nl);
    logic [23:0] a, b;
    int k, s;
    k = l / 2;
    if (md != 1) return pv(l % 2, k, p);
    a = pv(0, k, p);
    if ((l % 2) == 0 || k + 1 >= nl) return a;
    b = pv(0, k + 1, p);
    for (int c = 0; c < 3; c++) begin
      s = (int'(a[c*8 +: 8]) + int'(b[c*8 +: 8])) / 2;
      a[c*8 +: 8] = s[7:0];
    end
    return a;
  endfunction

  function automatic string data_tag();
    if (prev_stall) return "R7";
    if (rmode != int'(mode)) return "R8";
    if (rmode == 2) return "R10";
    if (rmode != 1) return "R2";
    if (rl == 2*int'(lpf) - 1) return "R4";
    return "R3";
  endfunction

  task automatic fill_store();
    for (int f = 0; f < 2; f++)
      for (int l = 0; l < MAX_LINES; l++)
        for (int p = 0; p < LINE_W; p++) begin
          @(negedge clk);
          wr_en = 1; wr_field = f[0]; wr_line = l[LOG2_LINES-1:0];
          wr_pix = p[LOG2_LINE_W-1:0]; wr_data = pv(f, l, p);
        end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic check_outputs();
    logic [23:0] e;
    vectors++;
    if (pix_valid !== (has != 0)) begin
      errors++;
      $display("FAIL R1: valid got %b expected %0d", pix_valid, has);
    end
    if (has != 0) begin
      e = expect_px(rmode, rl, rp, int'(lpf));
      if (pix_data !== e) begin
        errors++;
        $display("FAIL %s: data line %0d pix %0d got %h expected %h",
                 data_tag(), rl, rp, pix_data, e);
      end
      if (pix_hsync !== (rp == 0)) begin
        errors++;
        $display("FAIL R5: hsync got %b expected %0d", pix_hsync, rp == 0);
      end
      if (pix_vsync !== (rp == 0 && rl == 0)) begin
        errors++;
        $display("FAIL R6: vsync got %b expected %0d", pix_vsync, rp == 0 && rl == 0);
      end
    end
  endtask

  // decide what the next rising edge does, after inputs for it are set
  task automatic decide();
    if (has != 0 && pix_ready) begin
      // R9: frame length between frame starts
      if (pix_vsync === 1'b1) begin
        if (seen_frame != 0) begin
          vectors++;
          if (xfer_cnt != int'(ppl) * 2 * int'(lpf)) begin
            errors++;
            $display("FAIL R9: frame length got %0d expected %0d",
                     xfer_cnt, int'(ppl) * 2 * int'(lpf));
          end
        end
        seen_frame = 1; xfer_cnt = 0;
      end
      xfer_cnt++;
    end
    prev_stall = (has != 0 && !pix_ready);
    if (has == 0) begin
      rp = 0; rl = 0; rmode = int'(mode); has = 1;
    end else if (pix_ready) begin
      if (rp >= int'(ppl) - 1) begin
        rp = 0;
        rl = (rl >= 2*int'(lpf) - 1) ? 0 : rl + 1;
      end else rp++;
      if (rp == 0 && rl == 0) rmode = int'(mode);
    end
  endtask

  task automatic run_phase(int cycles, int mode_step);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_outputs();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i >= 200 && i < 230) pix_ready = 0;
      else pix_ready = (lfsr[2:0] != 3'd0);
      if (i % mode_step == mode_step / 2) mode = 2'((int'(mode) + 1) % 3);
      decide();
    end
  endtask

  task automatic start_phase(int np, int nl, int m);
    rst_n = 0; pix_ready = 0; has = 0; seen_frame = 0; xfer_cnt = 0;
    ppl = 16'(np); lpf = 16'(nl); mode = 2'(m);
    fill_store();
    @(negedge clk);
    vectors++;
    if (pix_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid in reset got %b expected 0", pix_valid);
    end
    rst_n = 1;
    pix_ready = 1;
    decide();
  endtask

  initial begin
    start_phase(5, 4, 0);
    run_phase(700, 113);
    start_phase(16, 8, 1);
    run_phase(2200, 397);
    start_phase(3, 1, 1);
    run_phase(120, 31);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run got stuck expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule